// File: doc/BRIEF.md
# Scanline Down-Counter Interrupt Unit

This block sits on the cartridge side of a video game system and produces an interrupt a set number of visible scanlines after the CPU arms it. The CPU writes an 8-bit line count to a load address. After that, each qualifying scanline pulse lowers the count by one. A scanline qualifies when its line number is in the visible range 0 to 239 and rendering is enabled.

When a nonzero count reaches zero, the block sets a pending flag and drives its interrupt request high. The count then rests at zero and does not reload. The request is a level. It stays high until the CPU writes to a separate acknowledge address. A new load does not clear it.

The scanline pulse comes from elsewhere. It is one cycle wide and carries the current 9-bit line number. All state is held in registers, and the interrupt output comes straight from a flop.

Top module: `scanline_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears the line count and the pending flag, so irq is low after reset and qualifying pulses that follow do not raise it.
- R2: A write to address 0xE003 loads the count with the data byte. irq then rises in the cycle after the N-th qualifying pulse, where N is the loaded value and is nonzero.
- R3: A write to address 0xE002, whatever its data, clears irq in the following cycle.
- R4: A scanline pulse whose line number is greater than 239 has no effect on the count.
- R5: A scanline pulse that arrives while render_on is low has no effect on the count.
- R6: When the count is zero, a qualifying pulse leaves it at zero and does not raise irq.
- R7: A qualifying pulse that takes the count from 1 to 0 sets irq high in the next cycle. The count then stays at zero.
- R8: Once irq is high, it stays high through any number of loads and pulses until an acknowledge write arrives.
- R9: When a load write and a qualifying pulse arrive in the same cycle, the count takes the written value and the pulse is dropped.
- R10: When an acknowledge write and a firing pulse (count 1, qualifying) arrive in the same cycle, irq is high afterwards.
- R11: Writes to any address other than 0xE002 and 0xE003 change neither the count nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle pulse at the start of each scanline |
| line_num | input | 9 | Line number that goes with line_pulse |
| render_on | input | 1 | High while display rendering is enabled |
| irq | output | 1 | Interrupt request level, registered |

## Verification
The hardest case to reach from the ports is a collision at the moment the count reaches zero. This covers a load or an acknowledge landing in the same cycle as the pulse that takes the count from 1 to 0. Random stimulus almost never lines these up, so directed sequences load a count of 1 and then put the write and the pulse on the same edge. The count itself cannot be seen at the ports. Its value is therefore inferred from the cycle in which irq rises, once the bench acknowledges and reloads. Long random runs then mix loads, acknowledges, stray writes and pulses on lines outside the visible range, with a bench reference model checking irq in every cycle.

// File: rtl/sli_pkg.sv
package sli_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ACK  = 2'd2
  } cpu_op_e;
endpackage

// File: rtl/sli_wr_decode.sv
module sli_wr_decode
  import sli_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LOAD_ADDR = 16'hE003,
  parameter logic [15:0] ACK_ADDR  = 16'hE002
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output cpu_op_e           op
);
  always_comb begin
    op = OP_NONE;
    if (we) begin
      if (addr == LOAD_ADDR[ADDR_W-1:0])     op = OP_LOAD;
      else if (addr == ACK_ADDR[ADDR_W-1:0]) op = OP_ACK;
    end
  end
endmodule

// File: rtl/sli_line_qual.sv
module sli_line_qual #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              pulse,
  input  logic [LINE_W-1:0] line,
  input  logic              render_on,
  output logic              tick
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);
  assign tick = pulse && render_on && (line <= LAST);
endmodule

// File: rtl/sli_counter.sv
module sli_counter
  import sli_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cpu_op_e          op,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             pending
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             do_load, do_dec, fire;

  assign do_load = (op == OP_LOAD);
  assign do_dec  = !do_load && tick && (cnt != '0);
  assign fire    = do_dec && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (do_load)     cnt <= load_val;
      else if (do_dec) cnt <= cnt - ONE;
      if (fire)              pending <= 1'b1;
      else if (op == OP_ACK) pending <= 1'b0;
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (cnt == $past(load_val)));
  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACK && !fire) |=> !pending);
  // R6
  zero_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && op != OP_LOAD) |=> (cnt == '0));
  // R7
  rise_from_one_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> ($past(cnt) == ONE && $past(tick)));
  // R8
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && op != OP_ACK) |=> pending);
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (do_load && tick) |=> (cnt == $past(load_val)));
  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && op != OP_LOAD) |=> $stable(cnt));
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import sli_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          LINE_W    = 9,
  parameter int          LAST_LINE = 239,
  parameter logic [15:0] LOAD_ADDR = 16'hE003,
  parameter logic [15:0] ACK_ADDR  = 16'hE002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              line_pulse,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq
);
  cpu_op_e op;
  logic    tick;

  sli_wr_decode #(.ADDR_W(ADDR_W), .LOAD_ADDR(LOAD_ADDR), .ACK_ADDR(ACK_ADDR)) u_dec (
    .we(cpu_we), .addr(cpu_addr), .op(op)
  );

  sli_line_qual #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_qual (
    .pulse(line_pulse), .line(line_num), .render_on(render_on), .tick(tick)
  );

  sli_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .op(op), .load_val(cpu_wdata), .tick(tick), .pending(irq)
  );
endmodule

// File: tb/scanline_irq_unit_tb.sv
module scanline_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        line_pulse;
  logic [8:0]  line_num;
  logic        render_on;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_cnt;
  logic       m_pend;
  bit         done = 0;

  always #5 clk = ~clk;

  scanline_irq_unit u_dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .line_pulse(line_pulse), .line_num(line_num), .render_on(render_on), .irq(irq)
  );

  function automatic bit qual_f(bit p, logic [8:0] ln, bit r);
    return p && r && (ln <= 9'd239);
  endfunction

  function automatic logic [8:0] next_f(logic [7:0] c, bit pend, bit we, logic [15:0] a,
                                        logic [7:0] d, bit q);
    bit ld, ak, fire;
    logic [7:0] nc;
    ld = we && a == 16'hE003;
    ak = we && a == 16'hE002;
    fire = !ld && q && c == 8'd1;
    nc = c;
    if (ld) nc = d;
    else if (q && c != 0) nc = c - 8'd1;
    if (fire) pend = 1'b1;
    else if (ak) pend = 1'b0;
    return {pend, nc};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(string req, bit we, logic [15:0] a, logic [7:0] d,
                     bit p, logic [8:0] ln, bit r);
    logic [8:0] nx;
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    line_pulse = p; line_num = ln; render_on = r;
    nx = next_f(m_cnt, m_pend, we, a, d, qual_f(p, ln, r));
    m_pend = nx[8]; m_cnt = nx[7:0];
    @(negedge clk);
    check(req, irq, m_pend);
  endtask

  task automatic idle(string req); cyc(req, 0, 16'h0, 8'h0, 0, 9'd0, 1); endtask
  task automatic load(string req, logic [7:0] v); cyc(req, 1, 16'hE003, v, 0, 9'd0, 1); endtask
  task automatic ack(string req); cyc(req, 1, 16'hE002, 8'h5A, 0, 9'd0, 1); endtask
  task automatic line(string req, logic [8:0] ln, bit r); cyc(req, 0, 16'h0, 8'h0, 1, ln, r); endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog irq actual=x expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    line_pulse = 0; line_num = 0; render_on = 0;
    m_cnt = 0; m_pend = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1", irq, 1'b0);
    // R1: pulses after reset do not fire
    for (int i = 0; i < 3; i++) line("R1", 9'd10, 1);
    check("R1", irq, 1'b0);

    // R2 / R7: load 3, three qualifying lines
    load("R2", 8'd3);
    line("R2", 9'd0, 1);
    line("R2", 9'd100, 1);
    check("R2", irq, 1'b0);
    line("R7", 9'd239, 1);
    check("R7", irq, 1'b1);
    // R6 / R8: at zero, more lines leave irq high and no refire issue
    line("R6", 9'd5, 1);
    // R8: reload does not clear
    load("R8", 8'd2);
    check("R8", irq, 1'b1);
    // R3: ack with any data
    ack("R3");
    check("R3", irq, 1'b0);

    // R4 / R5: out-of-range and render-off lines ignored (count still 2)
    line("R4", 9'd240, 1);
    line("R4", 9'd511, 1);
    line("R5", 9'd20, 0);
    line("R4", 9'd30, 1);
    check("R4", irq, 1'b0);
    line("R5", 9'd31, 1);
    check("R5", irq, 1'b1);
    ack("R3");

    // R6: zero count never fires
    load("R6", 8'd0);
    for (int i = 0; i < 4; i++) line("R6", 9'd50, 1);
    check("R6", irq, 1'b0);

    // R9: load and pulse together, load wins
    load("R9", 8'd1);
    cyc("R9", 1, 16'hE003, 8'd2, 1, 9'd7, 1);
    check("R9", irq, 1'b0);
    line("R9", 9'd8, 1);
    check("R9", irq, 1'b0);
    line("R9", 9'd9, 1);
    check("R9", irq, 1'b1);
    ack("R3");

    // R10: ack and firing pulse together, fire wins
    load("R10", 8'd1);
    cyc("R10", 1, 16'hE002, 8'h00, 1, 9'd1, 1);
    check("R10", irq, 1'b1);
    ack("R3");

    // R11: stray writes ignored
    load("R11", 8'd2);
    cyc("R11", 1, 16'hE001, 8'd0, 0, 9'd0, 1);
    cyc("R11", 1, 16'h6003, 8'd0, 0, 9'd0, 1);
    line("R11", 9'd3, 1);
    check("R11", irq, 1'b0);
    line("R11", 9'd4, 1);
    check("R11", irq, 1'b1);
    ack("R3");

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] a;
      k = $urandom_range(0, 9);
      case (k)
        0: a = 16'hE003;
        1: a = 16'hE002;
        2: a = 16'hE000 | 16'($urandom_range(0, 1));
        default: a = 16'($urandom);
      endcase
      cyc("R2", ($urandom_range(0, 3) == 0), a, 8'($urandom_range(0, 6)),
          ($urandom_range(0, 1) == 1), 9'($urandom_range(200, 280)),
          ($urandom_range(0, 5) != 0));
    end
    idle("R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule